// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block adds or subtracts two 64-bit words that are treated as a vector of equal-width lanes. A two-bit width select cuts the carry path at lane edges, so the same hardware works on eight byte lanes, four halfword lanes, two word lanes or one 64-bit value. A carry never leaks from one lane into the next.

Each lane can be read as signed or unsigned. Each lane also reports its own overflow. In wrap mode a lane keeps its result modulo 2^w. In saturating mode an overflowing lane is clamped to the bound it ran past. Media kernels that clip audio samples or pixel values are the typical users.

The datapath is combinational. An optional single register stage on the outputs is enabled by default.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_mode_i` selects the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 gives two 32-bit lanes and 3 gives one 64-bit lane. Lane k occupies bits k*w upward, and no carry or borrow crosses from one lane into the next.
- R2: With `sub_i`=0 every lane computes a+b. With `sub_i`=1 every lane computes a-b, formed as a plus the inverted b plus one injected at the lane's lowest bit. In wrap mode the result is taken modulo 2^w.
- R3: With `signed_i`=1 a lane flags overflow on add only when both operands have the same sign and the result sign differs. On subtract it flags overflow only when the operand signs differ and the result sign differs from a's sign.
- R4: With `signed_i`=0 a lane flags overflow on add when the true sum exceeds 2^w-1. On subtract it flags overflow when a < b, which is a borrow.
- R5: With `sat_i`=1 and `signed_i`=1, a lane that overflows upward yields 0x7F..F. A lane that overflows downward yields 0x80..0 for its width.
- R6: With `sat_i`=1 and `signed_i`=0, an overflowing add yields all ones and an overflowing subtract yields zero.
- R7: With `sat_i`=0 an overflowing lane still outputs its wrapped value and still raises its flag.
- R8: `ovf_o` bit k belongs to lane k. Bits at or above the active lane count read 0.
- R9: With the output register enabled, results and flags appear on the first rising clock edge after the inputs are applied and hold until the next edge. A synchronous active-high reset clears `res_o` and `ovf_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| lane_mode_i | input | 2 | Lane width select (log2 of bytes per lane) |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| signed_i | input | 1 | 1 = lanes are two's-complement, 0 = unsigned |
| sat_i | input | 1 | 1 = saturate on overflow, 0 = wrap |
| a_i | input | 64 | First operand vector |
| b_i | input | 64 | Second operand vector |
| res_o | output | 64 | Result vector |
| ovf_o | output | 8 | Per-lane overflow flags, packed from bit 0 |

## Verification
Every result and flag is due on the rising edge that follows the application of its operands, because exactly one register stage sits between the inputs and the ports. The bench changes inputs on the falling edge and samples 1 ns after the next rising edge. It also samples once just before that edge to confirm that the previous result is still held. Expected vectors come from a lane-by-lane model written from the requirements. That model uses wide arithmetic, so overflow and clamping are judged against true mathematical bounds and not against carry bits.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

  // Mask of segment index bits that lie inside one lane for a given width select.
  function automatic int span_mask(input int mode);
    return (1 << mode) - 1;
  endfunction

  // Saturation fill for one segment of a lane.
  function automatic logic [7:0] fill_byte(input logic is_signed, input logic is_sub,
                                           input logic top_seg, input logic neg_dir);
    logic [7:0] v;
    if (is_signed) begin
      if (top_seg) v = neg_dir ? 8'h80 : 8'h7F;
      else         v = neg_dir ? 8'h00 : 8'hFF;
    end else begin
      v = is_sub ? 8'h00 : 8'hFF;
    end
    return v;
  endfunction

endpackage

// File: rtl/simd_seg_ctrl.sv
module simd_seg_ctrl #(
  parameter int NUM_SEG = 8,
  parameter int MODE_W  = 2,
  parameter int IDX_W   = $clog2(NUM_SEG)
) (
  input  logic [MODE_W-1:0]                lane_mode_i,
  output logic [NUM_SEG-1:0]               first_o,
  output logic [NUM_SEG-1:0]               last_o,
  output logic [NUM_SEG-1:0][IDX_W-1:0]    end_idx_o,
  output logic [NUM_SEG-1:0][IDX_W-1:0]    lane_idx_o
);
  import simd_sat_pkg::*;

  logic [IDX_W-1:0] span_m;
  logic [IDX_W-1:0] idx;

  always_comb begin
    span_m = IDX_W'(span_mask(int'(lane_mode_i)));
    idx    = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      idx           = IDX_W'(i);
      first_o[i]    = (idx & span_m) == '0;
      last_o[i]     = (idx & span_m) == span_m;
      end_idx_o[i]  = idx | span_m;
      lane_idx_o[i] = idx >> lane_mode_i;
    end
  end

endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 8,
  parameter int DATA_W  = SEG_W * NUM_SEG
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic               sub_i,
  input  logic [NUM_SEG-1:0] first_i,
  output logic [DATA_W-1:0]  sum_o,
  output logic [NUM_SEG-1:0] cout_o
);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic             prev;
    logic             cin;
    logic [SEG_W:0]   tot;
    logic             co;

    if (g == 0) begin : g_head
      assign prev = 1'b0;
    end else begin : g_link
      assign prev = g_seg[g-1].co;
    end

    // lane start takes the negation's +1 (or 0 on add); otherwise the chain continues
    assign cin = first_i[g] ? sub_i : prev;
    assign tot = {1'b0, a_i[g*SEG_W +: SEG_W]}
               + {1'b0, b_i[g*SEG_W +: SEG_W] ^ {SEG_W{sub_i}}}
               + {{SEG_W{1'b0}}, cin};
    assign co  = tot[SEG_W];
    assign sum_o[g*SEG_W +: SEG_W] = tot[SEG_W-1:0];
    assign cout_o[g] = co;
  end

endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat #(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 8,
  parameter int IDX_W   = $clog2(NUM_SEG),
  parameter int DATA_W  = SEG_W * NUM_SEG
) (
  input  logic [DATA_W-1:0]             a_i,
  input  logic [DATA_W-1:0]             b_i,
  input  logic [DATA_W-1:0]             sum_i,
  input  logic [NUM_SEG-1:0]            cout_i,
  input  logic [NUM_SEG-1:0]            last_i,
  input  logic [NUM_SEG-1:0][IDX_W-1:0] end_idx_i,
  input  logic [NUM_SEG-1:0][IDX_W-1:0] lane_idx_i,
  input  logic                          sub_i,
  input  logic                          signed_i,
  input  logic                          sat_i,
  output logic [DATA_W-1:0]             res_o,
  output logic [NUM_SEG-1:0]            ovf_o
);

  logic [NUM_SEG-1:0] seg_ovf;
  logic [NUM_SEG-1:0] seg_neg;
  logic               a_s, bx_s, s_s;
  logic               s_ovf, u_ovf;
  logic [SEG_W-1:0]   fill;
  logic               top;

  // overflow detection at the top segment of each lane
  always_comb begin
    a_s = 1'b0; bx_s = 1'b0; s_s = 1'b0; s_ovf = 1'b0; u_ovf = 1'b0;
    for (int i = 0; i < NUM_SEG; i++) begin
      a_s        = a_i[i*SEG_W + SEG_W - 1];
      bx_s       = b_i[i*SEG_W + SEG_W - 1] ^ sub_i;
      s_s        = sum_i[i*SEG_W + SEG_W - 1];
      s_ovf      = (a_s == bx_s) && (s_s != a_s);
      u_ovf      = cout_i[i] ^ sub_i;
      seg_ovf[i] = last_i[i] & (signed_i ? s_ovf : u_ovf);
      seg_neg[i] = a_s;
    end
  end

  // result select: every segment looks up its lane's top segment
  always_comb begin
    fill = '0;
    top  = 1'b0;
    for (int j = 0; j < NUM_SEG; j++) begin
      top  = (IDX_W'(j) == end_idx_i[j]);
      fill = simd_sat_pkg::fill_byte(signed_i, sub_i, top, seg_neg[end_idx_i[j]]);
      res_o[j*SEG_W +: SEG_W] = (sat_i && seg_ovf[end_idx_i[j]])
                              ? fill : sum_i[j*SEG_W +: SEG_W];
    end
  end

  // pack lane flags from bit 0
  always_comb begin
    ovf_o = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (last_i[i]) ovf_o[lane_idx_i[i]] = seg_ovf[i];
    end
  end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [$clog2($clog2(NUM_SEG)+1)-1:0] lane_mode_i,
  input  logic                              sub_i,
  input  logic                              signed_i,
  input  logic                              sat_i,
  input  logic [SEG_W*NUM_SEG-1:0]          a_i,
  input  logic [SEG_W*NUM_SEG-1:0]          b_i,
  output logic [SEG_W*NUM_SEG-1:0]          res_o,
  output logic [NUM_SEG-1:0]                ovf_o
);
  localparam int DATA_W = SEG_W * NUM_SEG;
  localparam int IDX_W  = $clog2(NUM_SEG);
  localparam int MODE_W = $clog2(IDX_W + 1);
  localparam logic [MODE_W-1:0] MODE_FULL = MODE_W'(IDX_W);

  logic [NUM_SEG-1:0]            first, last;
  logic [NUM_SEG-1:0][IDX_W-1:0] end_idx, lane_idx;
  logic [DATA_W-1:0]             sum, res_c;
  logic [NUM_SEG-1:0]            cout, ovf_c;

  simd_seg_ctrl #(.NUM_SEG(NUM_SEG), .MODE_W(MODE_W), .IDX_W(IDX_W)) u_ctrl (
    .lane_mode_i (lane_mode_i),
    .first_o     (first),
    .last_o      (last),
    .end_idx_o   (end_idx),
    .lane_idx_o  (lane_idx)
  );

  simd_seg_adder #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .DATA_W(DATA_W)) u_add (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (sub_i),
    .first_i (first),
    .sum_o   (sum),
    .cout_o  (cout)
  );

  simd_lane_sat #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_sat (
    .a_i        (a_i),
    .b_i        (b_i),
    .sum_i      (sum),
    .cout_i     (cout),
    .last_i     (last),
    .end_idx_i  (end_idx),
    .lane_idx_i (lane_idx),
    .sub_i      (sub_i),
    .signed_i   (signed_i),
    .sat_i      (sat_i),
    .res_o      (res_c),
    .ovf_o      (ovf_c)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        res_o <= '0;
        ovf_o <= '0;
      end else begin
        res_o <= res_c;
        ovf_o <= ovf_c;
      end
    end

    AST_WRAP_FULL_SUB: assert property (@(posedge clk) disable iff (rst)
      (lane_mode_i == MODE_FULL && !sat_i && sub_i) |=> res_o == $past(a_i) - $past(b_i)); // R2
    AST_UOVF_FULL_ADD: assert property (@(posedge clk) disable iff (rst)
      (lane_mode_i == MODE_FULL && !signed_i && !sub_i)
        |=> ovf_o[0] == (DATA_W'($past(a_i) + $past(b_i)) < $past(a_i))); // R4
    AST_SSAT_LANE0_CLAMP: assert property (@(posedge clk) disable iff (rst)
      (lane_mode_i == '0 && sat_i && signed_i)
        |=> (!ovf_o[0] || res_o[SEG_W-1:0] == {1'b0, {(SEG_W-1){1'b1}}}
                       || res_o[SEG_W-1:0] == {1'b1, {(SEG_W-1){1'b0}}})); // R5
    AST_USAT_ADD_NOT_BELOW: assert property (@(posedge clk) disable iff (rst)
      (lane_mode_i == MODE_FULL && sat_i && !signed_i && !sub_i) |=> res_o >= $past(a_i)); // R6
    AST_USAT_SUB_NOT_ABOVE: assert property (@(posedge clk) disable iff (rst)
      (lane_mode_i == MODE_FULL && sat_i && !signed_i && sub_i) |=> res_o <= $past(a_i)); // R6
    AST_SINGLE_LANE_FLAGS: assert property (@(posedge clk) disable iff (rst)
      (lane_mode_i == MODE_FULL) |=> ovf_o[NUM_SEG-1:1] == '0); // R8
  end else begin : g_comb
    assign res_o = res_c;
    assign ovf_o = ovf_c;
  end

endmodule

// File: tb/tb_simd_sat_adder.sv
module tb_simd_sat_adder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  lane_mode_i = '0;
  logic        sub_i = 1'b0, signed_i = 1'b0, sat_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [63:0] res_o;
  logic [7:0]  ovf_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  simd_sat_adder dut (
    .clk(clk), .rst(rst), .lane_mode_i(lane_mode_i), .sub_i(sub_i),
    .signed_i(signed_i), .sat_i(sat_i), .a_i(a_i), .b_i(b_i),
    .res_o(res_o), .ovf_o(ovf_o)
  );

  // Lane model built from the requirements with wide arithmetic.
  function automatic void model(input logic [1:0] m, input logic s, input logic sg,
                                input logic st, input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] r, output logic [7:0] f);
    int w, n;
    w = 8 << m;
    n = 8 >> m;
    r = '0;
    f = '0;
    for (int k = 0; k < n; k++) begin
      logic [65:0] mask, sbit, av, bv, wrap, t, satv, lane;
      logic ov;
      mask = (66'd1 << w) - 66'd1;
      sbit = 66'd1 << (w - 1);
      av   = (66'(a) >> (k * w)) & mask;
      bv   = (66'(b) >> (k * w)) & mask;
      wrap = (s ? av - bv : av + bv) & mask;
      if (sg) begin
        t    = s ? ((av ^ sbit) - sbit) - ((bv ^ sbit) - sbit)
                 : ((av ^ sbit) - sbit) + ((bv ^ sbit) - sbit);
        ov   = ($signed(t) > $signed(sbit - 66'd1)) || ($signed(t) < -$signed(sbit));
        satv = ($signed(t) < 0) ? sbit : sbit - 66'd1;
      end else begin
        ov   = s ? (av < bv) : ((av + bv) > mask);
        satv = s ? 66'd0 : mask;
      end
      lane = (st && ov) ? satv : wrap;
      r = r | 64'(lane << (k * w));
      f[k] = ov;
    end
  endfunction

  task automatic run(input string tag, input logic [1:0] m, input logic s, input logic sg,
                     input logic st, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er;
    logic [7:0]  ef;
    model(m, s, sg, st, a, b, er, ef);
    @(negedge clk);
    lane_mode_i = m; sub_i = s; signed_i = sg; sat_i = st; a_i = a; b_i = b;
    @(posedge clk);
    #1;
    checks++;
    if (res_o !== er || ovf_o !== ef) begin
      failures++;
      $display("FAIL %s: mode=%0d sub=%0d sgn=%0d sat=%0d res=%h ovf=%b expected res=%h ovf=%b",
               tag, m, s, sg, st, res_o, ovf_o, er, ef);
    end
  endtask

  task automatic check_reset();
    @(negedge clk);
    rst = 1'b1; a_i = 64'hFFFF_FFFF_FFFF_FFFF; b_i = 64'h1; sat_i = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    checks++;
    if (res_o !== '0 || ovf_o !== '0) begin
      failures++;
      $display("FAIL R9: reset res=%h ovf=%b expected res=0 ovf=0", res_o, ovf_o);
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_latency();
    logic [63:0] held;
    run("R9", 2'd3, 1'b0, 1'b0, 1'b0, 64'd100, 64'd23);
    held = res_o;
    @(negedge clk);
    a_i = 64'd5; b_i = 64'd6;
    @(posedge clk);
    #(-0);
    checks++;
    if (held !== 64'd123) begin
      failures++;
      $display("FAIL R9: first result %h expected %h", held, 64'd123);
    end
    #1;
    checks++;
    if (res_o !== 64'd11) begin
      failures++;
      $display("FAIL R9: next-edge result %h expected %h", res_o, 64'd11);
    end
  endtask

  task automatic check_hold();
    run("R9", 2'd0, 1'b0, 1'b0, 1'b0, 64'h0101_0101_0101_0101, 64'h0202_0202_0202_0202);
    @(negedge clk);
    a_i = 64'h0; b_i = 64'h0;
    #3;
    checks++;
    if (res_o !== 64'h0303_0303_0303_0303) begin
      failures++;
      $display("FAIL R9: held result %h expected %h", res_o, 64'h0303_0303_0303_0303);
    end
  endtask

  task automatic check_lane_isolation();
    for (int m = 0; m < 4; m++) begin
      run("R1", 2'(m), 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
      run("R1", 2'(m), 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101);
    end
  endtask

  task automatic check_add_sub();
    for (int m = 0; m < 4; m++) begin
      run("R2", 2'(m), 1'b0, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h1111_2222_3333_4444);
      run("R2", 2'(m), 1'b1, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
    end
  endtask

  task automatic check_signed_flags();
    run("R3", 2'd0, 1'b0, 1'b1, 1'b0, 64'h7F80_7F00_0000_0000, 64'h01FF_8000_0000_0000);
    run("R3", 2'd0, 1'b1, 1'b1, 1'b0, 64'h807F_0001_0000_0000, 64'h01FF_8080_0000_0000);
    run("R3", 2'd1, 1'b0, 1'b1, 1'b0, 64'h7FFF_8000_1234_0000, 64'h0001_FFFF_8000_0000);
  endtask

  task automatic check_unsigned_flags();
    run("R4", 2'd0, 1'b0, 1'b0, 1'b0, 64'hFF80_0000_0000_00FE, 64'h0180_0000_0000_0001);
    run("R4", 2'd0, 1'b1, 1'b0, 1'b0, 64'h0010_0000_0000_0000, 64'h0111_0000_0000_0000);
    run("R4", 2'd3, 1'b1, 1'b0, 1'b0, 64'h1, 64'h2);
  endtask

  task automatic check_signed_sat();
    run("R5", 2'd0, 1'b0, 1'b1, 1'b1, 64'h7F80_7F00_1020_3040, 64'h01FF_8000_1020_3040);
    run("R5", 2'd1, 1'b1, 1'b1, 1'b1, 64'h8000_7FFF_0000_0005, 64'h0001_FFFF_8000_0003);
    run("R5", 2'd2, 1'b0, 1'b1, 1'b1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF);
    run("R5", 2'd3, 1'b1, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'h1);
  endtask

  task automatic check_unsigned_sat();
    run("R6", 2'd0, 1'b0, 1'b0, 1'b1, 64'hFF10_F000_0000_0000, 64'h0210_2000_0000_0000);
    run("R6", 2'd1, 1'b1, 1'b0, 1'b1, 64'h0001_0500_0000_0000, 64'h0002_0400_0000_0000);
    run("R6", 2'd3, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20);
  endtask

  task automatic check_wrap_flags();
    run("R7", 2'd0, 1'b0, 1'b1, 1'b0, 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101);
    run("R7", 2'd2, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0002);
  endtask

  task automatic check_packing();
    run("R8", 2'd1, 1'b0, 1'b0, 1'b0, 64'h0000_FFFF_0000_0000, 64'h0000_0001_0000_0000);
    run("R8", 2'd2, 1'b0, 1'b1, 1'b0, 64'h7FFF_FFFF_0000_0000, 64'h0000_0001_0000_0000);
    run("R8", 2'd3, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
  endtask

  task automatic sweep();
    logic [63:0] x, y;
    x = 64'h9E37_79B9_7F4A_7C15;
    y = 64'hC2B2_AE3D_27D4_EB4F;
    for (int i = 0; i < 256; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      y = y ^ (y << 13); y = y ^ (y >> 7); y = y ^ (y << 17);
      run("R1 R2 R3 R4 R5 R6 sweep", 2'(i), i[2], i[3], i[4], x, y);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    check_reset();
    check_latency();
    check_hold();
    check_lane_isolation();
    check_add_sub();
    check_signed_flags();
    check_unsigned_flags();
    check_signed_sat();
    check_unsigned_sat();
    check_wrap_flags();
    check_packing();
    sweep();
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_up();
  end

endmodule